// File: doc/BRIEF.md
# Programmable Priority Interrupt Controller

This block gathers eight edge-triggered interrupt lines and raises a single request output toward a processor. Software talks to it through a byte-wide port with two addresses. The even address takes commands and returns status. The odd address takes configuration words and the interrupt mask. At fixed priority, line 0 wins over line 7. An interrupt that is being serviced holds back every line of equal or lower priority until software ends it.

After reset the controller is dormant. Software wakes it by writing a start command to the even address, then three configuration words to the odd address. The first word is the vector base, the second is a cascade setting that is only stored, and the third is a mode word. Once the sequence is complete, the controller runs as follows:

- Odd-address writes load the mask.
- Software acknowledges the winning line with a poll command followed by an even read.
- Software retires the serviced interrupt with a non-specific end-of-interrupt command.
- A request on line 7 that vanishes before the poll read is reported as spurious.

Top module: `pic8_ctrl`

## Requirements
- R1: After reset the mask reads 0xFF at the odd address, `int_out` is low, and the device is uninitialized. While uninitialized, odd-address writes do not change the mask and `int_out` stays low.
- R2: An even-address write with bit 4 set (0x11) starts initialization. The next three odd-address writes are taken in order as vector base, cascade word and mode word, and none of them alters the mask. After the third, odd-address writes load the mask.
- R3: `vector_out` equals the vector base with its low three bits replaced by the number of the winning line, and bases 0x00 and 0x08 both work. `cascade_cfg` shows the stored cascade word.
- R4: A mask bit of 1 blocks that line, and a line that is only pending while masked never raises `int_out`.
- R5: A rising edge on a line sets its request bit. The bit clears when the line goes low or when the request is acknowledged by a poll. A line held high after acknowledgement does not set the bit again. The request register reads at the even address when it is selected, and it is the read selection after reset.
- R6: Line 0 has the highest priority. `int_out` is high only when an unmasked request has higher priority than every in-service bit.
- R7: An even write of 0x0C arms a poll. The next even read returns 0x80 ORed with the winning line number, sets that line's in-service bit and clears its request bit. Later even reads return the selected register again.
- R8: An even write of 0x0B selects the in-service register and 0x0A selects the request register for even reads. The selection persists until it is changed.
- R9: An even write of 0x20 clears the lowest-numbered (highest-priority) set bit of the in-service register.
- R10: A poll read when no request is eligible returns 0x07 (bit 7 clear) and leaves the in-service register unchanged. In particular, in-service bit 7 stays clear when the line 7 request vanished before the read.
- R11: A start-of-initialization write clears the in-service register, the request bits and any armed poll, and selects the request register. It leaves the mask unchanged.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Synchronous active-low reset |
| bus_wr | input | 1 | Write strobe, one cycle per write |
| bus_rd | input | 1 | Read strobe, one cycle per read |
| bus_addr | input | 1 | 0 selects the even address (commands/status), 1 the odd address (configuration/mask) |
| bus_wdata | input | 8 | Write data |
| bus_rdata | output | 8 | Read data, valid during the read strobe cycle |
| irq_in | input | 8 | Interrupt lines, active high, edge triggered |
| int_out | output | 1 | Interrupt request toward the processor |
| vector_out | output | 8 | Vector of the currently winning line |
| cascade_cfg | output | 8 | Stored cascade configuration word |

## Verification
The bench drives a request that vanishes before its poll read on line 7. A design that acknowledged it anyway would set in-service bit 7 and hide the spurious event. It ends nested interrupts with non-specific end-of-interrupt commands. A design that cleared the wrong bit would either unblock a lower line early or keep a higher one blocked. It holds a line high across its acknowledgement, where a level-sensitive latch would raise the request again. It also restarts initialization with a poll armed and a masked request latched, where a design that kept either would return 0x07 or raise a stale interrupt once the mask opened.

// File: rtl/pic8_pkg.sv
// Shared types and command codes for the 8-input priority interrupt controller.
// Assumes a byte-wide register port; codes are decoded on even-address writes.
package pic8_pkg;
    typedef enum logic [2:0] {
        CFG_OFF,
        CFG_BASE,
        CFG_CASC,
        CFG_MODE,
        CFG_READY
    } cfg_state_t;

    localparam int START_BIT = 4;           // set: begin initialization
    localparam int SEL_BIT   = 3;           // set (start clear): poll / read-select command
    localparam int POLL_BIT  = 2;           // poll request inside a select command
    localparam int RDEN_BIT  = 1;           // read-select change enable
    localparam logic [2:0] EOI_CODE = 3'b001;  // bits [7:5] of a non-specific EOI
endpackage

// File: rtl/pic8_lowidx.sv
// Finds the lowest set bit index of a vector (lowest index = highest priority).
// Assumes W is wide enough to hold N-1; idx is 0 when nothing is set.
module pic8_lowidx #(
    parameter int N = 8,
    parameter int W = $clog2(N)
) (
    input  logic [N-1:0] vec,
    output logic         any,
    output logic [W-1:0] idx
);
    // scan from the top so the lowest set index wins
    always_comb begin
        idx = '0;
        for (int i = N - 1; i >= 0; i--) begin
            if (vec[i]) idx = W'(i);
        end
        any = |vec;
    end
endmodule

// File: rtl/pic8_reqlat.sv
// Request register: latches rising edges of the lines, drops a bit when its line
// goes low or it is acknowledged. Assumes lines are already synchronous to clk.
module pic8_reqlat #(
    parameter int N = 8
) (
    input  logic         clk,
    input  logic         rst_n,
    input  logic [N-1:0] lines,
    input  logic [N-1:0] ack,
    input  logic         clr,
    output logic [N-1:0] req
);
    logic [N-1:0] prev_q;

    // remember last line levels for edge detection
    always_ff @(posedge clk) begin
        if (!rst_n) prev_q <= '0;
        else        prev_q <= lines;
    end

    // set on rising edge, hold while high, drop on low, ack or clear
    always_ff @(posedge clk) begin
        if (!rst_n || clr) req <= '0;
        else               req <= (req | (lines & ~prev_q)) & lines & ~ack;
    end
endmodule

// File: rtl/pic8_cfg.sv
// Initialization sequencer: after a start write it takes vector base, cascade
// and mode words from odd-address writes, then reports ready. Mode is accepted
// without decoding; only processor mode operation is supported.
module pic8_cfg
    import pic8_pkg::*;
#(
    parameter int W = 3
) (
    input  logic           clk,
    input  logic           rst_n,
    input  logic           start,
    input  logic           word_we,
    input  logic [7:0]     wdata,
    output logic           ready,
    output logic [7-W:0]   base_hi,
    output logic [7:0]     cascade
);
    cfg_state_t state_q;

    // step through the configuration words in order
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            state_q <= CFG_OFF;
            base_hi <= '0;
            cascade <= '0;
        end else if (start) begin
            state_q <= CFG_BASE;
        end else if (word_we) begin
            case (state_q)
                CFG_BASE: begin base_hi <= wdata[7:W]; state_q <= CFG_CASC; end
                CFG_CASC: begin cascade <= wdata;      state_q <= CFG_MODE; end
                CFG_MODE: state_q <= CFG_READY;
                default:  state_q <= state_q;
            endcase
        end
    end

    assign ready = (state_q == CFG_READY);
endmodule

// File: rtl/pic8_ctrl.sv
// Top of the 8-input fixed-priority interrupt controller. Holds mask, in-service
// register, read selection and poll arming; decodes the two-address byte port.
// Assumes reads and writes are never strobed in the same cycle.
module pic8_ctrl
    import pic8_pkg::*;
#(
    parameter int NUM_IRQ = 8
) (
    input  logic       clk,
    input  logic       rst_n,
    input  logic       bus_wr,
    input  logic       bus_rd,
    input  logic       bus_addr,
    input  logic [7:0] bus_wdata,
    output logic [7:0] bus_rdata,
    input  logic [7:0] irq_in,
    output logic       int_out,
    output logic [7:0] vector_out,
    output logic [7:0] cascade_cfg
);
    localparam int W = $clog2(NUM_IRQ);

    logic [NUM_IRQ-1:0] imr_q, isr_q, irr_q, prio_ok, elig, ack_vec;
    logic               sel_isr_q, poll_pend_q, ready;
    logic               isr_any, elig_any;
    logic [W-1:0]       isr_idx, win_idx;
    logic [7-W:0]       base_hi;
    logic               wr_even, wr_odd, start_w, cmd_w, eoi_w, sel_w, poll_rd;

    // decode the even/odd strobes into commands
    always_comb begin
        wr_even = bus_wr && !bus_addr;
        wr_odd  = bus_wr && bus_addr;
        start_w = wr_even && bus_wdata[START_BIT];
        cmd_w   = wr_even && !bus_wdata[START_BIT] && ready;
        sel_w   = cmd_w && bus_wdata[SEL_BIT];
        eoi_w   = cmd_w && !bus_wdata[SEL_BIT] && (bus_wdata[7:5] == EOI_CODE);
        poll_rd = bus_rd && !bus_addr && poll_pend_q;
    end

    pic8_cfg #(.W(W)) u_cfg (
        .clk(clk), .rst_n(rst_n), .start(start_w), .word_we(wr_odd),
        .wdata(bus_wdata), .ready(ready), .base_hi(base_hi), .cascade(cascade_cfg)
    );

    pic8_reqlat #(.N(NUM_IRQ)) u_req (
        .clk(clk), .rst_n(rst_n), .lines(irq_in), .ack(ack_vec),
        .clr(start_w), .req(irr_q)
    );

    pic8_lowidx #(.N(NUM_IRQ), .W(W)) u_isr_enc (
        .vec(isr_q), .any(isr_any), .idx(isr_idx)
    );

    // lines eligible: unmasked, and above every in-service priority
    always_comb begin
        for (int i = 0; i < NUM_IRQ; i++) begin
            prio_ok[i] = !isr_any || (i < int'(isr_idx));
        end
        elig = irr_q & ~imr_q & prio_ok;
    end

    pic8_lowidx #(.N(NUM_IRQ), .W(W)) u_win_enc (
        .vec(elig), .any(elig_any), .idx(win_idx)
    );

    // acknowledge the winner on a poll read
    always_comb begin
        ack_vec = '0;
        if (poll_rd && elig_any) ack_vec[win_idx] = 1'b1;
    end

    // mask register, loaded by odd writes once configured
    always_ff @(posedge clk) begin
        if (!rst_n)                imr_q <= '1;
        else if (wr_odd && ready)  imr_q <= bus_wdata[NUM_IRQ-1:0];
    end

    // in-service register: set by poll acknowledge, cleared by EOI or restart
    always_ff @(posedge clk) begin
        if (!rst_n || start_w)          isr_q <= '0;
        else if (poll_rd && elig_any)   isr_q[win_idx] <= 1'b1;
        else if (eoi_w && isr_any)      isr_q[isr_idx] <= 1'b0;
    end

    // read selection and poll arming
    always_ff @(posedge clk) begin
        if (!rst_n || start_w) begin
            sel_isr_q   <= 1'b0;
            poll_pend_q <= 1'b0;
        end else begin
            if (sel_w && bus_wdata[RDEN_BIT]) sel_isr_q <= bus_wdata[0];
            if (sel_w && bus_wdata[POLL_BIT]) poll_pend_q <= 1'b1;
            else if (poll_rd)                 poll_pend_q <= 1'b0;
        end
    end

    // read data mux
    always_comb begin
        if (bus_addr)         bus_rdata = imr_q;
        else if (poll_pend_q) bus_rdata = elig_any ? {1'b1, {(7-W){1'b0}}, win_idx}
                                                   : {{(8-W){1'b0}}, {W{1'b1}}};
        else if (sel_isr_q)   bus_rdata = isr_q;
        else                  bus_rdata = irr_q;
    end

    assign int_out    = ready && elig_any;
    assign vector_out = {base_hi, win_idx};
endmodule

// File: rtl/pic8_chk.sv
// Property checker for pic8_ctrl, attached by bind; observes ports and state.
module pic8_chk (
    input logic       clk,
    input logic       rst_n,
    input logic       bus_wr,
    input logic       bus_rd,
    input logic       bus_addr,
    input logic [7:0] bus_wdata,
    input logic       int_out,
    input logic       ready,
    input logic       poll_pend,
    input logic [7:0] irr,
    input logic [7:0] imr,
    input logic [7:0] isr
);
    // R1
    uninit_quiet_chk: assert property (@(posedge clk) disable iff (!rst_n)
        !ready |-> !int_out);

    // R4
    masked_quiet_chk: assert property (@(posedge clk) disable iff (!rst_n)
        int_out |-> ((irr & ~imr) != 8'h00));

    // R9
    eoi_clears_one_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (bus_wr && !bus_addr && ready && bus_wdata == 8'h20 && isr != 8'h00)
        |=> ($countones(isr) == $countones($past(isr)) - 1));

    // R7
    poll_sets_one_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (bus_rd && !bus_wr && !bus_addr && poll_pend && int_out)
        |=> ($countones(isr) == $countones($past(isr)) + 1));

    // R10
    spurious_no_isr_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (bus_rd && !bus_wr && !bus_addr && poll_pend && !int_out) |=> $stable(isr));
endmodule

bind pic8_ctrl pic8_chk u_chk (
    .clk(clk), .rst_n(rst_n), .bus_wr(bus_wr), .bus_rd(bus_rd),
    .bus_addr(bus_addr), .bus_wdata(bus_wdata), .int_out(int_out),
    .ready(ready), .poll_pend(poll_pend_q), .irr(irr_q), .imr(imr_q), .isr(isr_q)
);

// File: tb/pic8_ctrl_tb.sv
// Directed bench for pic8_ctrl: one task per scenario, each checking itself.
module pic8_ctrl_tb;
    logic       clk = 1'b0;
    logic       rst_n = 1'b0;
    logic       bus_wr = 1'b0, bus_rd = 1'b0, bus_addr = 1'b0;
    logic [7:0] bus_wdata = 8'h00, irq_in = 8'h00;
    logic [7:0] bus_rdata, vector_out, cascade_cfg;
    logic       int_out;
    int         n_vec = 0, n_bad = 0;
    bit         done = 1'b0;

    always #2 clk = ~clk;

    pic8_ctrl u_dut (
        .clk(clk), .rst_n(rst_n), .bus_wr(bus_wr), .bus_rd(bus_rd),
        .bus_addr(bus_addr), .bus_wdata(bus_wdata), .bus_rdata(bus_rdata),
        .irq_in(irq_in), .int_out(int_out), .vector_out(vector_out),
        .cascade_cfg(cascade_cfg)
    );

    task automatic chk(input string tag, input logic [7:0] act, input logic [7:0] exp);
        n_vec++;
        if (act !== exp) begin
            n_bad++;
            $display("FAIL %s actual=%02h expected=%02h", tag, act, exp);
        end
    endtask

    task automatic wr(input logic a, input logic [7:0] d);
        @(negedge clk); bus_wr = 1'b1; bus_addr = a; bus_wdata = d;
        @(negedge clk); bus_wr = 1'b0;
    endtask

    task automatic rd(input logic a, output logic [7:0] d);
        @(negedge clk); bus_rd = 1'b1; bus_addr = a;
        #1 d = bus_rdata;
        @(negedge clk); bus_rd = 1'b0;
    endtask

    task automatic lines(input logic [7:0] v);
        @(negedge clk); irq_in = v;
        repeat (2) @(negedge clk);
    endtask

    task automatic init(input logic [7:0] base, input logic [7:0] casc);
        wr(1'b0, 8'h11); wr(1'b1, base); wr(1'b1, casc); wr(1'b1, 8'h01);
    endtask

    task automatic t_reset();
        logic [7:0] d;
        rd(1'b1, d); chk("R1 reset mask", d, 8'hFF);
        chk("R1 reset int", {7'd0, int_out}, 8'h00);
        wr(1'b1, 8'h00); rd(1'b1, d); chk("R1 uninit mask write ignored", d, 8'hFF);
        lines(8'h01); chk("R1 uninit no int", {7'd0, int_out}, 8'h00);
        lines(8'h00);
    endtask

    task automatic t_init();
        logic [7:0] d;
        wr(1'b0, 8'h11); wr(1'b1, 8'h08);
        rd(1'b1, d); chk("R2 mask untouched mid-sequence", d, 8'hFF);
        wr(1'b1, 8'h04); wr(1'b1, 8'h01);
        chk("R3 cascade stored", cascade_cfg, 8'h04);
        wr(1'b1, 8'hFE); rd(1'b1, d); chk("R2 mask loads after init", d, 8'hFE);
    endtask

    task automatic t_mask();
        logic [7:0] d;
        lines(8'h08); chk("R4 masked line no int", {7'd0, int_out}, 8'h00);
        rd(1'b0, d); chk("R5 request latched", d, 8'h08);
        lines(8'h09); chk("R4 unmasked line int", {7'd0, int_out}, 8'h01);
        chk("R3 vector base 08 line 0", vector_out, 8'h08);
        lines(8'h00); rd(1'b0, d); chk("R5 low line clears request", d, 8'h00);
        wr(1'b1, 8'h00);
    endtask

    task automatic t_nest();
        logic [7:0] d;
        lines(8'h24); chk("R3 vector line 2", vector_out, 8'h0A);
        wr(1'b0, 8'h0C); rd(1'b0, d); chk("R7 poll returns line 2", d, 8'h82);
        chk("R6 lower line blocked by service", {7'd0, int_out}, 8'h00);
        wr(1'b0, 8'h0B); rd(1'b0, d); chk("R8 isr selected", d, 8'h04);
        rd(1'b0, d); chk("R8 selection persists", d, 8'h04);
        lines(8'h26); chk("R6 higher line breaks through", {7'd0, int_out}, 8'h01);
        wr(1'b0, 8'h0C); rd(1'b0, d); chk("R7 poll returns line 1", d, 8'h81);
        rd(1'b0, d); chk("R7 single poll read then isr", d, 8'h06);
        wr(1'b0, 8'h20); rd(1'b0, d); chk("R9 eoi clears highest priority", d, 8'h04);
        wr(1'b0, 8'h20); rd(1'b0, d); chk("R9 second eoi", d, 8'h00);
        chk("R6 line 5 released", {7'd0, int_out}, 8'h01);
        wr(1'b0, 8'h0C); rd(1'b0, d); chk("R7 poll returns line 5", d, 8'h85);
        wr(1'b0, 8'h20);
        wr(1'b0, 8'h0A); rd(1'b0, d); chk("R5 held lines not relatched", d, 8'h00);
        chk("R5 no int after ack", {7'd0, int_out}, 8'h00);
        lines(8'h00);
    endtask

    task automatic t_spurious();
        logic [7:0] d;
        lines(8'h80); chk("R3 vector line 7", vector_out, 8'h0F);
        lines(8'h00); chk("R10 vanished request", {7'd0, int_out}, 8'h00);
        wr(1'b0, 8'h0C); rd(1'b0, d); chk("R10 spurious poll value", d, 8'h07);
        wr(1'b0, 8'h0B); rd(1'b0, d); chk("R10 isr bit7 clear", d, 8'h00);
        lines(8'h80);
        wr(1'b0, 8'h0C); rd(1'b0, d); chk("R7 genuine line 7", d, 8'h87);
        rd(1'b0, d); chk("R7 isr bit7 set", d, 8'h80);
        wr(1'b0, 8'h20); lines(8'h00);
    endtask

    task automatic t_edge();
        logic [7:0] d;
        wr(1'b0, 8'h0A);
        lines(8'h10); rd(1'b0, d); chk("R5 rising edge latched", d, 8'h10);
        lines(8'h00); rd(1'b0, d); chk("R5 cleared when low", d, 8'h00);
    endtask

    task automatic t_reinit();
        logic [7:0] d;
        lines(8'h40);
        wr(1'b0, 8'h0C); rd(1'b0, d); chk("R7 poll line 6", d, 8'h86);
        wr(1'b1, 8'h0F); lines(8'h48);
        wr(1'b0, 8'h0C);
        init(8'h00, 8'h02);
        rd(1'b1, d); chk("R11 mask kept", d, 8'h0F);
        chk("R3 cascade slave id", cascade_cfg, 8'h02);
        rd(1'b0, d); chk("R11 poll dropped, irr cleared", d, 8'h00);
        wr(1'b0, 8'h0B); rd(1'b0, d); chk("R11 isr cleared", d, 8'h00);
        wr(1'b1, 8'h00);
        @(negedge clk); chk("R11 stale request gone", {7'd0, int_out}, 8'h00);
        lines(8'h40); lines(8'h48);
        chk("R3 base 00 int", {7'd0, int_out}, 8'h01);
        chk("R3 base 00 vector", vector_out, 8'h03);
        lines(8'h00);
    endtask

    initial begin
        repeat (3) @(negedge clk);
        rst_n = 1'b1;
        t_reset();
        t_init();
        t_mask();
        t_nest();
        t_spurious();
        t_edge();
        t_reinit();
        done = 1'b1;
        $display("== %0d vectors applied, %0d miscompares ==", n_vec, n_bad);
        $finish;
    end

    initial begin
        repeat (20000) @(posedge clk);
        if (!done) begin
            n_vec++; n_bad++;
            $display("FAIL watchdog actual=hung expected=done");
            $display("== %0d vectors applied, %0d miscompares ==", n_vec, n_bad);
            $finish;
        end
    end
endmodule